// File: doc/BRIEF.md
# Firmware ROM Patch Overlay Decoder

This block sits next to a system firmware ROM and substitutes a few small regions of it with bytes held in its own patch store. It watches the CPU read address and the chip-select for the lower 32 KB half of the firmware space (offsets 0000–7FFF). When an access lands in one of three patch windows, it pulls an active-low disable line that silences the internal ROM. It also raises an enable for its patch store and places the substituted byte on its data output. Every other access forwards the base ROM byte unchanged.

Matching is coarse. Only address bits A14..A5 are compared, so every window is a whole number of 32-byte strides. The store keeps a full image of each window, and that image includes the bytes that were not changed. There are three windows: a single stride at 08C0 that skips a start-up beep, a single stride at 0B80 that bypasses a long memory pattern test, and three strides at 1560 that hold a relocated keyboard handler.

The stored image of the firmware is elaborated from a fixed fill rule, given in R8, which stands in for the original ROM contents. A registered copy of the read data is captured on each read strobe.

Top module: `rom_overlay_dec`

## Requirements
- R1: While `fw_lo_sel_n` is high, `rom_dis_n` is 1, `patch_oe` is 0 and `rd_data` equals `rom_data`, whatever the address.
- R2: With `fw_lo_sel_n` low, a window is hit exactly when A14..A5 lies in stride 08C0–08DF, stride 0B80–0B9F or strides 1560–15BF. A4..A0 never change whether a window is hit.
- R3: On a hit, `rom_dis_n` is 0 and `patch_oe` is 1. With no hit, `rom_dis_n` is 1 and `patch_oe` is 0. The two outputs are always complementary and follow the address and select without a clock.
- R4: When no window is hit, `rd_data` equals `rom_data`.
- R5: Offsets 08DB, 08DC and 08DD read EB, 03 and EE from the patch store.
- R6: Offsets 0B90 and 0B91 read EB and DC from the patch store.
- R7: Offsets 156E–156F read E4 60. Offsets 1570–159E read the original byte of the offset two below. Offsets 159F–15A1 read 75 1F 90.
- R8: Every other byte inside a window reads the original firmware byte, whatever `rom_data` carries. The original byte at offset `o` is `o[7:0] XOR {o[14:8],1}`.
- R9: One clock after a cycle with `rd_stb` high, `rd_data_q` holds the `rd_data` of that cycle and `rd_valid_q` is 1. After a cycle without `rd_stb`, `rd_valid_q` is 0 and `rd_data_q` is unchanged.
- R10: During reset, `rd_data_q` is 0 and `rd_valid_q` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| fw_lo_sel_n | input | 1 | Active-low select of the lower firmware half |
| addr | input | 15 | Offset A14..A0 within the selected half |
| rd_stb | input | 1 | Read strobe; captures `rd_data` on the clock edge |
| rom_data | input | 8 | Byte from the base firmware ROM |
| rom_dis_n | output | 1 | Active-low disable of the base ROM |
| patch_oe | output | 1 | Enable for the patch store |
| rd_data | output | 8 | Patched or passed-through byte, combinational |
| rd_data_q | output | 8 | Registered copy of `rd_data` |
| rd_valid_q | output | 1 | High one cycle after a read strobe |

## Verification
On every cycle the assertions check several properties. The disable and enable outputs must be complementary and stay inactive whenever the select is off. Data must pass through whenever no window is hit. Changing only the low address bits must never drop a hit. The read register must capture on a strobe and hold without one.

Some behaviour only the bench scenarios can show. They confirm that the hit region matches the three windows exactly. They check the exact patched and relocated bytes, and that the original bytes inside a window come from the store rather than from the ROM bus. To do this, a full sweep of all 32768 offsets runs first, followed by a random phase that puts garbage on the ROM bus.

// File: rtl/ovl_pkg.sv
`timescale 1ns/1ps
package ovl_pkg;
    localparam int AW       = 15;
    localparam int DW       = 8;
    localparam int STRIDE_W = 5;
    localparam int STRIDE   = 1 << STRIDE_W;
    localparam int IDXW     = AW - STRIDE_W;
    localparam int NWIN     = 3;

    typedef logic [IDXW-1:0] stride_t;

    // first stride index of each window (A14..A5) and its length in strides
    localparam stride_t WIN_BASE [NWIN] = '{10'h046, 10'h05C, 10'h0AB};
    localparam int      WIN_LEN  [NWIN] = '{1, 1, 3};

    function automatic int win_first(int w);
        int acc = 0;
        for (int k = 0; k < NWIN; k++)
            if (k < w) acc += WIN_LEN[k] * STRIDE;
        return acc;
    endfunction

    localparam int DEPTH = win_first(NWIN);
    localparam int SAW   = $clog2(DEPTH);

    typedef struct packed {
        logic [DW-1:0] data;
        logic          vld;
    } rdreg_t;

    // stand-in image of the unmodified firmware
    function automatic logic [DW-1:0] orig_byte(logic [AW-1:0] off);
        return off[7:0] ^ {off[14:8], 1'b1};
    endfunction

    // image served by the overlay at a given offset
    function automatic logic [DW-1:0] image_byte(logic [AW-1:0] off);
        logic [DW-1:0] b;
        case (off)
            15'h08DB: b = 8'hEB;
            15'h08DC: b = 8'h03;
            15'h08DD: b = 8'hEE;
            15'h0B90: b = 8'hEB;
            15'h0B91: b = 8'hDC;
            15'h156E: b = 8'hE4;
            15'h156F: b = 8'h60;
            15'h159F: b = 8'h75;
            15'h15A0: b = 8'h1F;
            15'h15A1: b = 8'h90;
            default: begin
                if (off >= 15'h1570 && off <= 15'h159E) b = orig_byte(off - 15'd2);
                else                                    b = orig_byte(off);
            end
        endcase
        return b;
    endfunction

    // firmware offset held by store entry i
    function automatic logic [AW-1:0] entry_offset(int i);
        int rem = i;
        logic [AW-1:0] off = '0;
        for (int w = 0; w < NWIN; w++) begin
            if (rem >= 0 && rem < WIN_LEN[w] * STRIDE)
                off = AW'(int'(WIN_BASE[w]) * STRIDE + rem);
            rem -= WIN_LEN[w] * STRIDE;
        end
        return off;
    endfunction
endpackage

// File: rtl/ovl_window_match.sv
`timescale 1ns/1ps
module ovl_window_match
    import ovl_pkg::*;
(
    input  logic           sel_n,
    input  logic [AW-1:0]  addr,
    output logic [NWIN-1:0] hit,
    output logic [SAW-1:0] idx
);
    stride_t        stride;
    logic [SAW-1:0] idx_w [NWIN];

    assign stride = addr[AW-1:STRIDE_W];

    for (genvar w = 0; w < NWIN; w++) begin : g_win
        localparam int      FIRST = win_first(w);
        localparam stride_t LO    = WIN_BASE[w];
        localparam stride_t HI    = stride_t'(int'(WIN_BASE[w]) + WIN_LEN[w] - 1);
        logic in_rng;
        assign in_rng   = (stride >= LO) && (stride <= HI);
        assign hit[w]   = !sel_n && in_rng;
        assign idx_w[w] = hit[w]
            ? SAW'(FIRST + int'(stride - LO) * STRIDE + int'(addr[STRIDE_W-1:0]))
            : '0;
    end

    always_comb begin
        idx = '0;
        for (int w = 0; w < NWIN; w++) idx = idx | idx_w[w];
    end
endmodule

// File: rtl/ovl_patch_store.sv
`timescale 1ns/1ps
module ovl_patch_store
    import ovl_pkg::*;
(
    input  logic [SAW-1:0] idx,
    output logic [DW-1:0]  data
);
    logic [DW-1:0] mem [DEPTH];

    for (genvar i = 0; i < DEPTH; i++) begin : g_ent
        localparam logic [DW-1:0] VAL = image_byte(entry_offset(i));
        assign mem[i] = VAL;
    end

    always_comb begin
        data = '0;
        for (int i = 0; i < DEPTH; i++)
            if (idx == SAW'(i)) data = mem[i];
    end
endmodule

// File: rtl/rom_overlay_dec.sv
`timescale 1ns/1ps
module rom_overlay_dec
    import ovl_pkg::*;
(
    input  logic          clk,
    input  logic          rst_n,
    input  logic          fw_lo_sel_n,
    input  logic [AW-1:0] addr,
    input  logic          rd_stb,
    input  logic [DW-1:0] rom_data,
    output logic          rom_dis_n,
    output logic          patch_oe,
    output logic [DW-1:0] rd_data,
    output logic [DW-1:0] rd_data_q,
    output logic          rd_valid_q
);
    logic [NWIN-1:0] hit;
    logic [SAW-1:0]  idx;
    logic [DW-1:0]   store_data;
    logic            any_hit;
    rdreg_t          r_d, r_q;

    ovl_window_match u_match (
        .sel_n (fw_lo_sel_n),
        .addr  (addr),
        .hit   (hit),
        .idx   (idx)
    );

    ovl_patch_store u_store (
        .idx  (idx),
        .data (store_data)
    );

    assign any_hit   = |hit;
    assign patch_oe  = any_hit;
    assign rom_dis_n = !any_hit;
    assign rd_data   = any_hit ? store_data : rom_data;

    always_comb begin
        r_d     = r_q;
        r_d.vld = rd_stb;
        if (rd_stb) r_d.data = rd_data;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) r_q <= '0;
        else        r_q <= r_d;
    end

    assign rd_data_q  = r_q.data;
    assign rd_valid_q = r_q.vld;
endmodule

// File: rtl/ovl_checker.sv
`timescale 1ns/1ps
module ovl_checker
    import ovl_pkg::*;
(
    input logic          clk,
    input logic          rst_n,
    input logic          fw_lo_sel_n,
    input logic [AW-1:0] addr,
    input logic          rd_stb,
    input logic [DW-1:0] rom_data,
    input logic          rom_dis_n,
    input logic          patch_oe,
    input logic [DW-1:0] rd_data,
    input logic [DW-1:0] rd_data_q,
    input logic          rd_valid_q
);
    p_idle_r1: assert property (@(posedge clk) disable iff (!rst_n)
        fw_lo_sel_n |-> (rom_dis_n && !patch_oe && rd_data == rom_data));

    p_pair_r3: assert property (@(posedge clk) disable iff (!rst_n)
        rom_dis_n != patch_oe);

    p_pass_r4: assert property (@(posedge clk) disable iff (!rst_n)
        rom_dis_n |-> rd_data == rom_data);

    p_coarse_r2: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(!rom_dis_n) && !fw_lo_sel_n && addr != $past(addr)
         && addr[AW-1:STRIDE_W] == $past(addr[AW-1:STRIDE_W])) |-> !rom_dis_n);

    p_capture_r9: assert property (@(posedge clk) disable iff (!rst_n)
        rd_stb |=> (rd_valid_q && rd_data_q == $past(rd_data)));

    p_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !rd_stb |=> (!rd_valid_q && $stable(rd_data_q)));
endmodule

bind rom_overlay_dec ovl_checker chk_i (.*);

// File: tb/rom_overlay_dec_tb.sv
`timescale 1ns/1ps
module rom_overlay_dec_tb_top;
    logic        clk = 1'b0;
    logic        rst_n;
    logic        fw_lo_sel_n;
    logic [14:0] addr;
    logic        rd_stb;
    logic [7:0]  rom_data;
    logic        rom_dis_n, patch_oe, rd_valid_q;
    logic [7:0]  rd_data, rd_data_q;

    int  n_run  = 0;
    int  n_fail = 0;
    bit  done   = 0;
    logic [7:0] exp_q = 8'h00;

    always #2.5 clk = ~clk;

    rom_overlay_dec dut_i (
        .clk(clk), .rst_n(rst_n), .fw_lo_sel_n(fw_lo_sel_n), .addr(addr),
        .rd_stb(rd_stb), .rom_data(rom_data), .rom_dis_n(rom_dis_n),
        .patch_oe(patch_oe), .rd_data(rd_data), .rd_data_q(rd_data_q),
        .rd_valid_q(rd_valid_q)
    );

    function automatic logic [7:0] m_orig(logic [14:0] o);
        return o[7:0] ^ {o[14:8], 1'b1};
    endfunction

    function automatic bit m_in_win(logic [14:0] o);
        return (o >= 15'h08C0 && o <= 15'h08DF) || (o >= 15'h0B80 && o <= 15'h0B9F)
            || (o >= 15'h1560 && o <= 15'h15BF);
    endfunction

    function automatic logic [7:0] m_win_byte(logic [14:0] o);
        case (o)
            15'h08DB: return 8'hEB;  15'h08DC: return 8'h03;  15'h08DD: return 8'hEE;
            15'h0B90: return 8'hEB;  15'h0B91: return 8'hDC;
            15'h156E: return 8'hE4;  15'h156F: return 8'h60;
            15'h159F: return 8'h75;  15'h15A0: return 8'h1F;  15'h15A1: return 8'h90;
            default: ;
        endcase
        if (o >= 15'h1570 && o <= 15'h159E) return m_orig(o - 15'd2);
        return m_orig(o);
    endfunction

    function automatic string m_req(bit sel_n, logic [14:0] o);
        if (sel_n)                           return "R1";
        if (!m_in_win(o))                    return "R4";
        if (o >= 15'h08DB && o <= 15'h08DD)  return "R5";
        if (o >= 15'h0B90 && o <= 15'h0B91)  return "R6";
        if (o >= 15'h156E && o <= 15'h15A1)  return "R7";
        return "R8";
    endfunction

    task automatic check(bit ok, string req, int act, int exp, string what);
        n_run++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    task automatic step(bit sel_n, logic [14:0] a, bit stb, logic [7:0] rd);
        bit         hit;
        logic [7:0] ed;
        @(negedge clk);
        fw_lo_sel_n = sel_n; addr = a; rd_stb = stb; rom_data = rd;
        hit = !sel_n && m_in_win(a);
        ed  = hit ? m_win_byte(a) : rd;
        #1;
        check(rom_dis_n == !hit, sel_n ? "R1" : "R2", rom_dis_n, !hit, $sformatf("rom_dis_n @%h", a));
        check(patch_oe == hit, "R3", patch_oe, hit, $sformatf("patch_oe @%h", a));
        check(rd_data == ed, m_req(sel_n, a), rd_data, ed, $sformatf("rd_data @%h", a));
        @(posedge clk);
        #1;
        if (stb) exp_q = ed;
        check(rd_valid_q == stb, "R9", rd_valid_q, stb, "rd_valid_q");
        check(rd_data_q == exp_q, "R9", rd_data_q, exp_q, "rd_data_q");
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'h5EED_0A11));
        rst_n = 1'b0; fw_lo_sel_n = 1'b1; addr = '0; rd_stb = 1'b0; rom_data = '0;
        repeat (3) @(posedge clk);
        #1;
        check(rd_data_q == 8'h00, "R10", rd_data_q, 0, "rd_data_q in reset");
        check(rd_valid_q == 1'b0, "R10", rd_valid_q, 0, "rd_valid_q in reset");
        @(negedge clk);
        rst_n = 1'b1;

        // directed: select off at patched offsets with unrelated bus data (R1)
        step(1'b1, 15'h08DB, 1'b1, 8'h3C);
        step(1'b1, 15'h156E, 1'b0, 8'hA5);
        // directed window edges (R2) and hold without strobe (R9)
        step(1'b0, 15'h08BF, 1'b1, m_orig(15'h08BF));
        step(1'b0, 15'h08C0, 1'b0, 8'h00);
        step(1'b0, 15'h15BF, 1'b1, 8'hFF);
        step(1'b0, 15'h15C0, 1'b0, 8'h77);

        // full sweep with the base ROM carrying the original image
        for (int o = 0; o < 32768; o++)
            step(1'b0, 15'(o), 1'b1, m_orig(15'(o)));

        // random phase: garbage on the ROM bus, addresses biased to windows
        for (int n = 0; n < 3000; n++) begin
            logic [14:0] a;
            case ($urandom % 4)
                0: a = 15'h08C0 + 15'($urandom % 32);
                1: a = 15'h0B80 + 15'($urandom % 32);
                2: a = 15'h1560 + 15'($urandom % 96);
                default: a = 15'($urandom);
            endcase
            step(($urandom % 4) == 0, a, 1'($urandom), 8'($urandom));
        end

        done = 1;
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end
endmodule